// File: doc/BRIEF.md
# One-Second Decimal Digit Flasher

This block steps one seven-segment display through the decimal digits 0 to 9 and then starts again at 0. Each digit stays on the display for about one second. All registers run on one system clock. A wide free-running prescaler counter gives a single-cycle enable pulse each time it reaches its terminal value. That pulse moves a decade counter on by one, and a combinational decoder turns the decade counter's value into active-low segment drive.

The prescaler has two modes, chosen by a parameter. In rollover mode it counts through every value of its `PRESCALE_W` bits, and the pulse comes when all bits are one. With a 26-bit prescaler on a 50 MHz clock, this holds each digit for about 1.34 s. In exact mode the prescaler clears after a programmed terminal count. With 49,999,999 on a 50 MHz clock, each digit lasts exactly 1.000 s. A synchronous active-high reset clears both counters. The current digit is also brought out as a debug output.

Top module: `digit_flasher`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counters clear. After that edge, `digit_dbg` reads 0 and `seg_n` reads 7'b1000000.
- R2: `digit_dbg` changes only on a clock edge where the internal enable pulse is high. On every other edge it holds its value.
- R3: On each enable edge the digit goes up by one. From 9 it goes to 0. `digit_dbg` never shows a value above 9.
- R4: In rollover mode (`EXACT_MODE` = 0), the enable is high for one cycle out of every 2^`PRESCALE_W`. The first digit change comes on the 2^`PRESCALE_W`-th rising edge after reset is released.
- R5: In exact mode (`EXACT_MODE` = 1), the enable is high for one cycle out of every `TERMINAL_COUNT`+1. The prescaler returns to 0 on the edge after the enable.
- R6: `seg_n` is active-low, with bit order {g,f,e,d,c,b,a} from bit 6 down to bit 0. The codes are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.
- R7: `seg_n` follows `digit_dbg` in the same cycle, with no extra register stage.
- R8: A reset applied part-way through a digit restarts both the digit and the spacing. The next change again comes a full period after the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Every register in the block uses it. |
| rst | input | 1 | Synchronous active-high reset. |
| seg_n | output | 7 | Active-low segment drive, bit order {g,f,e,d,c,b,a}. |
| digit_dbg | output | 4 | Digit currently shown, 0 to 9. |

## Verification
The assertions assume that `rst` is a clean level, sampled only at rising clock edges, and that it is held high from time zero until at least one edge has passed. Before that first edge the registers have no defined value. The step and hold properties also assume that the two counters are the only state in the design, so no digit change can happen without an enable pulse. The bench holds reset from time zero and changes it only at falling edges. It runs one small rollover-mode instance and one small exact-mode instance, long enough for several full 0-to-9 cycles each. In the middle of the run it applies a reset mid-digit.

// File: rtl/digflash_pkg.sv
package digflash_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam int LAST_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // Successor in the decade sequence 0..9, wrapping to 0.
  function automatic digit_t decade_next(input digit_t cur);
    if (cur >= digit_t'(LAST_DIGIT)) return '0;
    return cur + digit_t'(1);
  endfunction

  // Active-low segment pattern, bit order {g,f,e,d,c,b,a}.
  function automatic seg_t seg_pattern(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int          PRESCALE_W     = 26,
  parameter bit          EXACT_MODE     = 1'b0,
  parameter int unsigned TERMINAL_COUNT = 49_999_999
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam logic [PRESCALE_W-1:0] ALL_ONES = {PRESCALE_W{1'b1}};
  localparam logic [PRESCALE_W-1:0] LAST_VAL =
    EXACT_MODE ? PRESCALE_W'(TERMINAL_COUNT) : ALL_ONES;

  logic [PRESCALE_W-1:0] count_q;
  logic                  at_last;

  assign at_last = (count_q == LAST_VAL);
  assign tick    = at_last;

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (at_last) count_q <= '0;
    else              count_q <= count_q + PRESCALE_W'(1);
  end

  // Reset clears the prescaler: R1 / R8
  p_prescale_clear_r8: assert property (@(posedge clk) rst |=> count_q == '0);

  // Away from the terminal value the prescaler only counts up by one: R4 / R5
  p_prescale_step_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> count_q == $past(count_q) + PRESCALE_W'(1));

  generate
    if (EXACT_MODE) begin : g_exact
      // The count after the terminal value is always zero: R5
      p_exact_restart_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> count_q == '0);
    end else begin : g_rollover
      // The pulse lasts one cycle and is followed by a natural rollover: R4
      p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick && count_q == '0);
    end
  endgenerate

endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import digflash_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  output digit_t digit
);

  digit_t digit_q;

  always_ff @(posedge clk) begin
    if (rst)       digit_q <= '0;
    else if (step) digit_q <= decade_next(digit_q);
  end

  assign digit = digit_q;

  // The digit holds between enable pulses: R2
  p_hold_without_step_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(digit));

  // Below nine, an enable pulse moves the digit up by one: R3
  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (step && digit != 4'd9) |=> digit == $past(digit) + 4'd1);

  // From nine, an enable pulse returns the digit to zero: R3
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && digit == 4'd9) |=> digit == 4'd0);

  // The digit stays in the range 0..9: R3
  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    digit <= 4'd9);

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import digflash_pkg::*;
(
  input  digit_t digit,
  output seg_t   seg_n
);

  assign seg_n = seg_pattern(digit);

endmodule

// File: rtl/digit_flasher.sv
module digit_flasher
  import digflash_pkg::*;
#(
  parameter int          PRESCALE_W     = 26,
  parameter bit          EXACT_MODE     = 1'b0,
  parameter int unsigned TERMINAL_COUNT = 49_999_999
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg_n,
  output logic [3:0] digit_dbg
);

  logic   adv_tick;
  digit_t cur_digit;
  seg_t   seg_drive;

  tick_prescaler #(
    .PRESCALE_W     (PRESCALE_W),
    .EXACT_MODE     (EXACT_MODE),
    .TERMINAL_COUNT (TERMINAL_COUNT)
  ) u_prescaler (
    .clk  (clk),
    .rst  (rst),
    .tick (adv_tick)
  );

  decade_counter u_decade (
    .clk   (clk),
    .rst   (rst),
    .step  (adv_tick),
    .digit (cur_digit)
  );

  seg_decoder u_decoder (
    .digit (cur_digit),
    .seg_n (seg_drive)
  );

  assign seg_n     = seg_drive;
  assign digit_dbg = cur_digit;

  // After a reset edge the display shows a zero: R1
  p_reset_shows_zero_r1: assert property (@(posedge clk)
    rst |=> digit_dbg == 4'd0 && seg_n == 7'b1000000);

  // Every valid digit lights at least two segments: R6
  p_segments_lit_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(~seg_n) >= 2);

  // The segment outputs change only when the digit changes: R7
  p_seg_tracks_digit_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(digit_dbg) |-> $stable(seg_n));

endmodule

// File: tb/digit_flasher_bench.sv
module digit_flasher_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] seg_a, seg_b;
  logic [3:0] dig_a, dig_b;

  always #4 clk = ~clk;

  // Rollover mode, 4-bit prescaler: 16 cycles per digit.
  digit_flasher #(.PRESCALE_W(4), .EXACT_MODE(1'b0), .TERMINAL_COUNT(0)) u_digit_flasher (
    .clk(clk), .rst(rst), .seg_n(seg_a), .digit_dbg(dig_a));

  // Exact mode, terminal 6: 7 cycles per digit.
  digit_flasher #(.PRESCALE_W(4), .EXACT_MODE(1'b1), .TERMINAL_COUNT(6)) u_digit_flasher_exact (
    .clk(clk), .rst(rst), .seg_n(seg_b), .digit_dbg(dig_b));

  // Bench's own segment table, {g,f,e,d,c,b,a}, active-low.
  localparam logic [6:0] SEG_REF [10] = '{
    7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10 };

  int  ref_pre_a, ref_dig_a, ref_pre_b, ref_dig_b;
  int  compared = 0;
  int  mismatched = 0;
  bit  done = 1'b0;

  // Behavioural reference: cycles elapsed in the current digit, and the digit.
  always @(posedge clk) begin
    if (rst) begin
      ref_pre_a = 0; ref_dig_a = 0; ref_pre_b = 0; ref_dig_b = 0;
    end else begin
      if (ref_pre_a == 15) begin ref_pre_a = 0; ref_dig_a = (ref_dig_a + 1) % 10; end
      else ref_pre_a = ref_pre_a + 1;
      if (ref_pre_b == 6) begin ref_pre_b = 0; ref_dig_b = (ref_dig_b + 1) % 10; end
      else ref_pre_b = ref_pre_b + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(dig_a == 4'(ref_dig_a), "R3 digit sequence (rollover)", int'(dig_a), ref_dig_a);
    check(seg_a == SEG_REF[ref_dig_a], "R6 segment code (rollover)", int'(seg_a), int'(SEG_REF[ref_dig_a]));
    if (dig_a < 4'd10)
      check(seg_a == SEG_REF[dig_a], "R7 segments follow digit", int'(seg_a), int'(SEG_REF[dig_a]));
    else
      check(1'b0, "R3 digit above nine", int'(dig_a), 9);
    check(dig_b == 4'(ref_dig_b), "R5 digit sequence (exact)", int'(dig_b), ref_dig_b);
    check(seg_b == SEG_REF[ref_dig_b], "R6 segment code (exact)", int'(seg_b), int'(SEG_REF[ref_dig_b]));
  endtask

  initial begin
    int first_change;
    int changes_a;
    int changes_b;
    bit saw_wrap;
    logic [3:0] prev_a, prev_b;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(dig_a == 4'd0, "R1 reset digit", int'(dig_a), 0);
    check(seg_a == 7'b1000000, "R1 reset segments", int'(seg_a), 'h40);
    check(dig_b == 4'd0, "R1 reset digit (exact)", int'(dig_b), 0);
    rst = 1'b0;

    first_change = -1; changes_a = 0; changes_b = 0; saw_wrap = 1'b0;
    prev_a = dig_a; prev_b = dig_b;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      compare_all();
      if (dig_a != prev_a) begin
        changes_a++;
        if (first_change < 0) first_change = k;
        if (prev_a == 4'd9 && dig_a == 4'd0) saw_wrap = 1'b1;
      end
      if (dig_b != prev_b) changes_b++;
      prev_a = dig_a; prev_b = dig_b;
    end
    check(first_change == 16, "R4 first change edge", first_change, 16);
    check(changes_a == 25, "R2 change count (rollover)", changes_a, 25);
    check(changes_b == 57, "R5 change count (exact)", changes_b, 57);
    check(saw_wrap, "R3 nine wraps to zero", int'(saw_wrap), 1);

    // R8: reset in the middle of a digit
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(dig_a == 4'd0, "R8 mid-run reset digit", int'(dig_a), 0);
    check(dig_b == 4'd0, "R8 mid-run reset digit (exact)", int'(dig_b), 0);
    rst = 1'b0;
    first_change = -1; prev_a = dig_a;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      compare_all();
      if (dig_a != prev_a && first_change < 0) first_change = k;
      prev_a = dig_a;
    end
    check(first_change == 16, "R8 spacing restarts", first_change, 16);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule